// File: doc/BRIEF.md
# SPI Burst Exchange Engine

This block moves data between a transmit queue and a receive queue over a four-wire serial link. It takes 32-bit words from the transmit queue. Each word goes out one byte at a time, starting with the lowest byte. The bytes clocked in during the same transfers are packed back into a 32-bit word, and that word is handed to the receive queue. A burst is a programmable number of bits. It can be shorter than a word, or it can stretch across several words, because the remaining bit count carries over from one word to the next and from one run to the next.

A run is started by a transmit write, by the immediate-start bit being raised, or by an exchange request. The run then continues word by word. In continuous-burst mode it keeps going until the transmit queue is empty. In every other mode it stops at the end of each burst. The engine raises a sticky done flag and a sticky overflow flag, and it owns the exchange bit. The serial side runs in clock mode 0, with a serial clock derived from the system clock by a fixed divider. Both queues and the chip-select lines belong to the surrounding logic.

Top module: `spi_burst_engine`

## Requirements
- R1: A burst lasts `len_field + 1` bits. This count is loaded only when the remaining bit count is zero or negative. Otherwise the count left over from the previous word, or from the previous run, is used without reloading.
- R2: Each word popped from the transmit queue sends ceil(min(remaining, 32) / 8) bytes, starting with bits 7:0. The remaining count drops by 8 for every byte. A pop is always followed by shifting, never by a second pop.
- R3: The byte received during the k-th byte of a word (k counting from 0) lands in bits 8k+7:8k of the receive word. Byte positions that were not exchanged read 0. The word is offered to the receive queue after its last byte.
- R4: If `rx_full` is high when a word is ready, the word is dropped and `ovf` is set. `ovf` stays set until `ovf_clr` is pulsed.
- R5: Continuous-burst mode holds when bit `chan_sel` of `chan_master` is 1, `smc` is 0, and bit `chan_sel` of `ss_ctl` is 1. In this mode `xch` is set whenever a new burst length is loaded.
- R6: When a burst ends outside continuous-burst mode, `tc` is set and the engine returns to idle, even if the transmit queue still holds data.
- R7: When the engine finds the transmit queue empty, `tc` is set, `xch` is cleared, and the engine returns to idle.
- R8: A run starts only when bit `chan_sel` of `chan_master` is 1, on any one of three events: `tx_write` while `smc` is 1; `smc` rising while the transmit queue is not empty; or `xch_req` while `xch` is 0 and `smc` is 0. The last of these also sets `xch`. Any other combination leaves the engine idle.
- R9: The serial clock is in mode 0. `sclk` is low when idle. Each bit lasts DIV system clocks, with `sclk` high for the last DIV/2 of them. `mosi` carries each byte most significant bit first and holds steady across the rising edge. `miso` is sampled at that rising edge.
- R10: `busy` is high from the cycle after an accepted start until the engine stops. Start events that arrive while `busy` is high are ignored.
- R11: After reset, `busy`, `tc`, `ovf`, `xch`, `sclk`, `tx_pop` and `rx_push` are all 0. Pulsing `tc_clr` clears `tc`, and pulsing `ovf_clr` clears `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_field | input | LEN_W | Burst length minus one, in bits |
| chan_master | input | NCH | Per-channel master-mode bits |
| ss_ctl | input | NCH | Per-channel continuous-burst select bits |
| chan_sel | input | CH_W | Selected channel |
| smc | input | 1 | Immediate-start mode |
| tx_write | input | 1 | Strobe: a word was written to the transmit queue |
| xch_req | input | 1 | Strobe: software requests an exchange |
| tc_clr | input | 1 | Clears `tc` |
| ovf_clr | input | 1 | Clears `ovf` |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_data | input | 32 | Head word of the transmit queue (show-ahead) |
| tx_pop | output | 1 | Removes the head of the transmit queue |
| rx_full | input | 1 | Receive queue is full |
| rx_data | output | 32 | Word offered to the receive queue |
| rx_push | output | 1 | Writes `rx_data` into the receive queue |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A run is in progress |
| tc | output | 1 | Sticky transfer-complete flag |
| ovf | output | 1 | Sticky receive-overflow flag |
| xch | output | 1 | Exchange bit |

## Verification
The assertions check four things on every cycle. A pop is always followed by shifting. An overflow only appears after the receive queue was full. `mosi` holds steady across each rising serial clock edge. At every stop, `tc` is set, and `xch` is clear if the transmit queue is empty. They also check that a non-master channel never starts a run. Some behaviour is only visible in the bench scenarios: how many bytes each word sends, bit counts carried across word and run boundaries, the placement of received bytes, continuous-burst continuation versus stopping per burst, overflow dropping, and start events ignored while busy. For these, a behavioural model predicts every serial byte, every received word and the final flags.

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int DIV   = 4,
  parameter int LEN_W = 12,
  parameter int NCH   = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_field,
  input  logic [NCH-1:0]   chan_master,
  input  logic [NCH-1:0]   ss_ctl,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             smc,
  input  logic             tx_write,
  input  logic             xch_req,
  input  logic             tc_clr,
  input  logic             ovf_clr,
  input  logic             tx_empty,
  input  logic [31:0]      tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic [31:0]      rx_data,
  output logic             rx_push,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             tc,
  output logic             ovf,
  output logic             xch
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int REM_W = LEN_W + 2;

  typedef enum logic [1:0] {IDLE, CHK, XFER, PUSH} st_t;
  st_t st;

  logic [REM_W-1:0] rem, bl, rem_eff, span;
  logic [31:0]      sh, rxw;
  logic [7:0]       rxb;
  logic [2:0]       bitc, nb_left, nbytes;
  logic [1:0]       idx;
  logic [CNT_W-1:0] div;
  logic             smc_q, is_mst, multi, rem_done, xch_go, start;

  assign is_mst   = chan_master[chan_sel];
  assign multi    = is_mst & ~smc & ss_ctl[chan_sel];
  assign rem_done = rem[REM_W-1] | (rem == '0);
  assign bl       = REM_W'(len_field) + REM_W'(1);
  assign rem_eff  = rem_done ? bl : rem;
  assign span     = (rem_eff > REM_W'(32)) ? REM_W'(32) : rem_eff;
  assign nbytes   = 3'((span + REM_W'(7)) >> 3);
  assign xch_go   = xch_req & ~xch & ~smc;
  assign start    = (st == IDLE) & is_mst &
                    ((tx_write & smc) | (smc & ~smc_q & ~tx_empty) | xch_go);

  assign busy    = (st != IDLE);
  assign tx_pop  = (st == CHK) & ~tx_empty;
  assign rx_push = (st == PUSH) & ~rx_full;
  assign rx_data = rxw;
  assign sclk    = (st == XFER) & (div >= CNT_W'(HALF));
  assign mosi    = (st == XFER) & sh[3'd7 - bitc];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      rem     <= '0;
      sh      <= '0;
      rxw     <= '0;
      rxb     <= '0;
      bitc    <= '0;
      nb_left <= '0;
      idx     <= '0;
      div     <= '0;
      smc_q   <= 1'b0;
      tc      <= 1'b0;
      ovf     <= 1'b0;
      xch     <= 1'b0;
    end else begin
      smc_q <= smc;
      if (tc_clr)  tc  <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st <= CHK;
          if (xch_go) xch <= 1'b1;
        end
        CHK: if (tx_empty) begin
          tc  <= 1'b1;
          xch <= 1'b0;
          st  <= IDLE;
        end else begin
          rem <= rem_eff;
          if (rem_done && multi) xch <= 1'b1;
          sh      <= tx_data;
          rxw     <= '0;
          idx     <= '0;
          bitc    <= '0;
          div     <= '0;
          nb_left <= nbytes;
          st      <= XFER;
        end
        XFER: begin
          div <= (div == CNT_W'(DIV - 1)) ? '0 : div + CNT_W'(1);
          if (div == CNT_W'(HALF - 1)) rxb <= {rxb[6:0], miso};
          if (div == CNT_W'(DIV - 1)) begin
            bitc <= bitc + 3'd1;
            if (bitc == 3'd7) begin
              rxw[{idx, 3'b000} +: 8] <= rxb;
              sh      <= sh >> 8;
              idx     <= idx + 2'd1;
              rem     <= rem - REM_W'(8);
              nb_left <= nb_left - 3'd1;
              if (nb_left == 3'd1) st <= PUSH;
            end
          end
        end
        PUSH: begin
          if (rx_full) ovf <= 1'b1;
          if (rem_done && !multi) begin
            tc <= 1'b1;
            if (tx_empty) xch <= 1'b0;
            st <= IDLE;
          end else begin
            st <= CHK;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk #(
  parameter int NCH = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            tc,
  input logic            ovf,
  input logic            xch,
  input logic            tx_empty,
  input logic            tx_pop,
  input logic            rx_full,
  input logic            sclk,
  input logic            mosi,
  input logic [NCH-1:0]  chan_master,
  input logic [CH_W-1:0] chan_sel
);
  p_pop_then_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (busy && !tx_pop));

  p_ovf_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(rx_full));

  p_stop_sets_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tc);

  p_empty_stop_xch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && tx_empty) |-> !xch);

  p_no_master_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !chan_master[chan_sel]) |=> !busy);

  p_mosi_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
endmodule

bind spi_burst_engine spi_burst_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tc(tc), .ovf(ovf), .xch(xch),
  .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_full(rx_full), .sclk(sclk),
  .mosi(mosi), .chan_master(chan_master), .chan_sel(chan_sel)
);

// File: tb/test_spi_burst_engine.sv
module test_spi_burst_engine;
  localparam int DIV = 4, LEN_W = 12, NCH = 4, RXD = 4;

  logic clk = 0, rst_n = 0;
  logic [LEN_W-1:0] len_field = '0;
  logic [NCH-1:0] chan_master = '0, ss_ctl = '0;
  logic [1:0] chan_sel = 2'd1;
  logic smc = 0, tx_write = 0, xch_req = 0, tc_clr = 0, ovf_clr = 0;
  logic tx_empty = 1, rx_full = 0, miso_r = 0;
  logic [31:0] tx_data = '0, rx_data;
  logic tx_pop, rx_push, sclk, mosi, busy, tc, ovf, xch;

  always #2 clk = ~clk;

  spi_burst_engine #(.DIV(DIV), .LEN_W(LEN_W), .NCH(NCH)) i_spi_burst_engine (
    .clk(clk), .rst_n(rst_n), .len_field(len_field), .chan_master(chan_master),
    .ss_ctl(ss_ctl), .chan_sel(chan_sel), .smc(smc), .tx_write(tx_write),
    .xch_req(xch_req), .tc_clr(tc_clr), .ovf_clr(ovf_clr), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full), .rx_data(rx_data),
    .rx_push(rx_push), .sclk(sclk), .mosi(mosi), .miso(miso_r), .busy(busy),
    .tc(tc), .ovf(ovf), .xch(xch));

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] txq[$], rxq[$], exp_rx[$];
  logic [7:0]  exp_mosi[$];
  bit pend_pop = 0;
  int m_rem = 0, m_nb = 0, m_left = 0;
  bit m_tc = 0, m_ovf = 0, m_xch = 0;
  int sl_nb = 0, sl_bits = 0, hi_cnt = 0;
  logic [7:0] sl_sh = '0;

  function automatic logic [7:0] resp(int n);
    return 8'((n * 37 + 91) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // queue models, per-clock output comparison
  always @(negedge clk) begin
    logic [31:0] e;
    if (pend_pop && txq.size() > 0) void'(txq.pop_front());
    pend_pop = tx_pop;
    if (rx_push) begin
      rxq.push_back(rx_data);
      if (exp_rx.size() == 0) chk(0, "R3", "unexpected rx word", rx_data, 0);
      else begin
        e = exp_rx.pop_front();
        chk(rx_data == e, "R3", "rx word", rx_data, e);
      end
    end
    if (rst_n && !busy)
      chk(!sclk && !tx_pop && !rx_push, "R9", "idle outputs", {sclk, tx_pop, rx_push}, 0);
    if (sclk) hi_cnt++;
    else begin
      if (hi_cnt != 0) chk(hi_cnt == DIV / 2, "R9", "sclk high time", hi_cnt, DIV / 2);
      hi_cnt = 0;
    end
    tx_empty = (txq.size() == 0);
    tx_data  = (txq.size() > 0) ? txq[0] : '0;
    rx_full  = (rxq.size() >= RXD);
  end

  // serial slave
  always @(posedge sclk) begin
    logic [7:0] e;
    sl_sh = {sl_sh[6:0], mosi};
    sl_bits++;
    if (sl_bits == 8) begin
      sl_bits = 0;
      sl_nb++;
      if (exp_mosi.size() == 0) chk(0, "R2", "unexpected mosi byte", sl_sh, 0);
      else begin
        e = exp_mosi.pop_front();
        chk(sl_sh == e, "R2", "mosi byte", sl_sh, e);
      end
    end
  end

  always @(negedge sclk) begin
    logic [7:0] r;
    r = resp(sl_nb);
    miso_r = r[3'(7 - sl_bits)];
  end

  task automatic model_run(bit multi, int bl);
    logic [31:0] tq[$];
    logic [31:0] w, rx;
    int rc, n, idx;
    tq = txq;
    rc = rxq.size();
    forever begin
      if (tq.size() == 0) begin m_tc = 1; m_xch = 0; break; end
      if (m_rem <= 0) begin m_rem = bl; if (multi) m_xch = 1; end
      w = tq.pop_front();
      n = (m_rem < 32) ? m_rem : 32;
      rx = '0;
      idx = 0;
      while (n > 0) begin
        exp_mosi.push_back(w[idx*8 +: 8]);
        rx[idx*8 +: 8] = resp(m_nb);
        m_nb++; n -= 8; m_rem -= 8; idx++;
      end
      if (rc >= RXD) m_ovf = 1;
      else begin exp_rx.push_back(rx); rc++; end
      if (m_rem <= 0 && !multi) begin
        m_tc = 1;
        if (tq.size() == 0) m_xch = 0;
        break;
      end
    end
    m_left = tq.size();
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_flags();
    tc_clr = 1; ovf_clr = 1; step(); tc_clr = 0; ovf_clr = 0; step();
    m_tc = 0; m_ovf = 0;
  endtask

  // kind 0: tx_write, 1: smc rising, 2: xch_req
  task automatic run(string req, int kind, bit poke);
    bit multi;
    int t;
    if (kind == 1) begin smc = 0; step(2); end
    multi = chan_master[chan_sel] && !(kind == 1 ? 1'b1 : smc) && ss_ctl[chan_sel];
    if (kind == 2) m_xch = 1;
    model_run(multi, int'(len_field) + 1);
    case (kind)
      0: begin tx_write = 1; step(); tx_write = 0; end
      1: begin smc = 1; step(); end
      default: begin xch_req = 1; step(); xch_req = 0; end
    endcase
    t = 0;
    while (!busy && t < 10) begin step(); t++; end
    chk(busy, "R10", "busy after start", busy, 1);
    if (multi) chk(xch == 1, "R5", "xch during continuous burst", xch, 1);
    if (poke) begin
      step(5);
      tx_write = 1; xch_req = 1; step(); tx_write = 0; xch_req = 0;
    end
    t = 0;
    while (busy && t < 20000) begin step(); t++; end
    step(3);
    chk(exp_mosi.size() == 0, req, "bytes left unsent", exp_mosi.size(), 0);
    chk(exp_rx.size() == 0, req, "rx words missing", exp_rx.size(), 0);
    chk(tc == m_tc, req, "tc", tc, m_tc);
    chk(ovf == m_ovf, "R4", "ovf", ovf, m_ovf);
    chk(xch == m_xch, "R7", "xch", xch, m_xch);
    chk(txq.size() == m_left, "R6", "tx words left", txq.size(), m_left);
  endtask

  task automatic no_start(string req, int kind);
    bit seen = 0;
    bit x0 = xch;
    case (kind)
      0: begin tx_write = 1; step(); tx_write = 0; end
      1: begin smc = 0; step(2); smc = 1; step(); end
      default: begin xch_req = 1; step(); xch_req = 0; end
    endcase
    repeat (6) begin if (busy) seen = 1; step(); end
    chk(!seen, req, "no start expected", seen, 0);
    chk(xch == x0, req, "xch unchanged", xch, x0);
  endtask

  task automatic flush();
    txq.delete(); rxq.delete(); step(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R11 reset state
    chk({busy, tc, ovf, xch, sclk, tx_pop, rx_push} == 0, "R11", "reset outputs",
        {busy, tc, ovf, xch, sclk, tx_pop, rx_push}, 0);
    chan_master = 4'b0010;

    // R8: smc rising with empty queue does not start
    no_start("R8", 1);

    // R1/R2/R7: 8-bit burst, single byte, queue drains
    len_field = 12'd7;
    txq.push_back(32'h11223344);
    run("R7", 0, 0);

    // R11: clear flags
    clr_flags();
    chk(tc == 0 && ovf == 0, "R11", "flags cleared", {tc, ovf}, 0);

    // R6: 32-bit burst stops with a word left
    len_field = 12'd31;
    txq.push_back(32'hA1B2C3D4); txq.push_back(32'h0F1E2D3C);
    run("R6", 0, 0);
    clr_flags(); flush();

    // R1: 64-bit burst carried across two runs
    len_field = 12'd63;
    txq.push_back(32'hDEADBEEF);
    run("R1", 0, 0);
    clr_flags(); flush();
    txq.push_back(32'h01234567);
    run("R1", 0, 0);
    clr_flags(); flush();

    // R3: 48-bit burst, second word half filled
    len_field = 12'd47;
    txq.push_back(32'h89ABCDEF); txq.push_back(32'h76543210);
    run("R3", 0, 0);
    clr_flags(); flush();

    // R2: 12-bit burst rounds up to two bytes
    len_field = 12'd11;
    txq.push_back(32'hCAFEF00D);
    run("R2", 0, 0);
    clr_flags(); flush();

    // R10: start events during a run are ignored
    len_field = 12'd31;
    txq.push_back(32'h5A5A1234);
    run("R10", 0, 1);
    clr_flags(); flush();

    // R5: continuous-burst mode, 16-bit bursts over three words
    smc = 0; ss_ctl = 4'b0010; step(2);
    len_field = 12'd15;
    txq.push_back(32'h00AA0011); txq.push_back(32'h00BB0022); txq.push_back(32'h00CC0033);
    run("R5", 2, 0);
    clr_flags(); flush();

    // R4: overflow with continuous bursts
    len_field = 12'd31;
    rxq.push_back(32'h1); rxq.push_back(32'h2); rxq.push_back(32'h3);
    txq.push_back(32'h13579BDF); txq.push_back(32'h2468ACE0);
    run("R4", 2, 0);
    clr_flags();
    chk(ovf == 0, "R4", "ovf cleared", ovf, 0);
    flush();

    // R8: not master, no start; smc set blocks exchange request
    ss_ctl = 4'b0000;
    chan_master = 4'b0000;
    smc = 1; step(2);
    txq.push_back(32'h77665544);
    no_start("R8", 0);
    chan_master = 4'b0010; step();
    no_start("R8", 2);
    // R8: smc rising with data queued starts a run
    len_field = 12'd7;
    run("R8", 1, 0);
    clr_flags(); flush();

    // R6: ordinary burst by exchange request stops with data left, xch kept
    smc = 0; step(2);
    len_field = 12'd7;
    txq.push_back(32'h000000E1); txq.push_back(32'h000000E2);
    run("R6", 2, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule